// File: doc/BRIEF.md
# ISA I/O and Expansion-ROM Address Decoder

This block holds a 16-bit configuration word and turns it into two chip-select signals for an ISA-style bus. The upper byte sets where a 16-location register window sits in the 64k I/O space. The lower byte sets the size and placement of an expansion-ROM window in memory space. The I/O compare also requires a fixed set of address lines to be zero, so every I/O address decodes to at most one window.

A serial-EEPROM loader writes the whole configuration word through a parallel port at start-up. A host can later rewrite either byte on its own. Both selects are combinational functions of the bus address, the read strobe, the mode input and the stored word. A change to the word reaches the selects on the cycle after the clock edge that stores it. When `isa_mode` is low, both selects stay low.

Top module: `isa_addr_decoder`

## Requirements
- R1: A synchronous active-high reset sets `cfg_q` to 1867h. This gives an I/O window at 300h and a 16k ROM window at CC000h.
- R2: On a host write, the byte enables pick the bytes that change. `wr_be[0]` writes bits 7..0 and `wr_be[1]` writes bits 15..8. A byte whose enable is clear keeps its value. With no write and no load, `cfg_q` holds.
- R3: A loader strobe replaces all 16 bits with `ld_value` at the next clock edge. It takes priority over a host write in the same cycle.
- R4: `io_sel` compares I/O address bits A15..A13 with `cfg_q[15:13]` and bits A9..A5 with `cfg_q[12:8]`.
- R5: `io_sel` also requires A12, A11, A10 and A4 to be zero. Bits A3..A0 do not affect it.
- R6: When the size code `cfg_q[7:6]` is 00, `rom_sel` never asserts.
- R7: `cfg_q[5:1]` hold the ROM base bits RA18..RA14, and `cfg_q[0]` is unused. Size code 01 makes a 16k window and compares A18..A14. Code 10 makes a 32k window and compares A18..A15. Code 11 makes a 64k window and compares A18..A16.
- R8: `rom_sel` requires memory address bit A19 to be 1. Bits A23..A20 do not affect it.
- R9: `rom_sel` asserts only while the active-low read strobe `mem_rd_n` is 0.
- R10: When `isa_mode` is 0, both `io_sel` and `rom_sel` are 0.
- R11: A change to `cfg_q` moves the selects only after the clock edge that stores it. Before that edge, the selects follow the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| isa_mode | input | 1 | Enables both selects when high |
| ld_valid | input | 1 | Loader strobe, overwrites the whole word |
| ld_value | input | 16 | Word from the setup loader |
| wr_en | input | 1 | Host write strobe |
| wr_be | input | 2 | Host byte enables |
| wr_data | input | 16 | Host write data |
| cfg_q | output | 16 | Current configuration word (read-back) |
| io_addr | input | 16 | Bus I/O address |
| mem_addr | input | 24 | Bus memory address |
| mem_rd_n | input | 1 | Active-low memory read strobe |
| io_sel | output | 1 | I/O window select |
| rom_sel | output | 1 | Expansion-ROM select |

## Verification
The assertions assume that reset is held high for the first clock edge. They also assume that the address and strobe inputs change only away from the rising edge, so the combinational selects are settled when they are sampled. The bench drives every input on the falling edge and holds reset from time zero. Each configuration word reaches the block through the loader or host port and is never forced inside it. The selects are therefore always judged against a word stored by a real clock edge.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;
  localparam int CFG_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int NBYTES  = CFG_W / BYTE_W;
  localparam int IO_AW   = 16;
  localparam int ROM_LSB = 14;  // lowest window base bit (16k granule)
  localparam int ROM_NB  = 5;   // base bits RA18..RA14
  localparam logic [CFG_W-1:0] CFG_DEFAULT = 16'h1867;

  typedef enum logic [1:0] {
    SPAN_OFF = 2'b00,
    SPAN_16K = 2'b01,
    SPAN_32K = 2'b10,
    SPAN_64K = 2'b11
  } rom_span_e;
endpackage

// File: rtl/cfg_word_reg.sv
module cfg_word_reg
  import isa_dec_pkg::*;
#(
  parameter int                 WIDTH   = CFG_W,
  parameter int                 LANE_W  = BYTE_W,
  parameter logic [WIDTH-1:0]   INIT    = CFG_DEFAULT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld_valid,
  input  logic [WIDTH-1:0]         ld_value,
  input  logic                     wr_en,
  input  logic [WIDTH/LANE_W-1:0]  wr_be,
  input  logic [WIDTH-1:0]         wr_data,
  output logic [WIDTH-1:0]         q
);
  localparam int LANES = WIDTH / LANE_W;

  logic [LANE_W-1:0] lane_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        lane_q[g] <= INIT[g*LANE_W +: LANE_W];
      else if (ld_valid)
        lane_q[g] <= ld_value[g*LANE_W +: LANE_W];
      else if (wr_en && wr_be[g])
        lane_q[g] <= wr_data[g*LANE_W +: LANE_W];
    end
    assign q[g*LANE_W +: LANE_W] = lane_q[g];
  end
endmodule

// File: rtl/io_window_match.sv
module io_window_match
  import isa_dec_pkg::*;
#(
  parameter int AW = IO_AW
) (
  input  logic [AW-1:0] io_addr,
  input  logic [7:0]    base_byte,
  output logic          hit
);
  // Compared lines: A15..A13 against base_byte[7:5], A9..A5 against [4:0].
  // Forced-zero lines: A12..A10 and A4.
  localparam int HI_TOP = 15;
  localparam int HI_BOT = 13;
  localparam int MID_TOP = 9;
  localparam int MID_BOT = 5;

  logic hi_eq, mid_eq, zeros_ok;

  always_comb begin
    hi_eq    = (io_addr[HI_TOP:HI_BOT] == base_byte[7:5]);
    mid_eq   = (io_addr[MID_TOP:MID_BOT] == base_byte[4:0]);
    zeros_ok = (io_addr[HI_BOT-1:MID_TOP+1] == '0) && !io_addr[MID_BOT-1];
    hit      = hi_eq && mid_eq && zeros_ok;
  end
endmodule

// File: rtl/rom_window_match.sv
module rom_window_match
  import isa_dec_pkg::*;
#(
  parameter int MAW = 24,
  parameter int LSB = ROM_LSB,
  parameter int NB  = ROM_NB
) (
  input  logic [MAW-1:0] mem_addr,
  input  rom_span_e      span,
  input  logic [NB-1:0]  base,
  input  logic           rd_n,
  output logic           hit
);
  localparam int TOP_BIT = LSB + NB; // the line that must read 1 (A19)

  logic [NB-1:0] miss;
  logic [1:0]    span_code;

  assign span_code = span;

  // Base bit k joins the compare once the window is small enough:
  // 16k uses k>=0, 32k k>=1, 64k k>=2.
  for (genvar k = 0; k < NB; k++) begin : g_bit
    logic used;
    assign used    = (span != SPAN_OFF) && ((k + 1) >= int'(span_code));
    assign miss[k] = used && (mem_addr[LSB+k] != base[k]);
  end

  assign hit = (span != SPAN_OFF) && !rd_n && mem_addr[TOP_BIT] && (miss == '0);
endmodule

// File: rtl/isa_addr_decoder.sv
module isa_addr_decoder
  import isa_dec_pkg::*;
#(
  parameter int                 MEM_AW    = 24,
  parameter logic [CFG_W-1:0]   RESET_CFG = CFG_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              isa_mode,
  input  logic              ld_valid,
  input  logic [CFG_W-1:0]  ld_value,
  input  logic              wr_en,
  input  logic [NBYTES-1:0] wr_be,
  input  logic [CFG_W-1:0]  wr_data,
  output logic [CFG_W-1:0]  cfg_q,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_rd_n,
  output logic              io_sel,
  output logic              rom_sel
);
  logic      io_hit, rom_hit;
  rom_span_e span;

  cfg_word_reg #(.WIDTH(CFG_W), .LANE_W(BYTE_W), .INIT(RESET_CFG)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .ld_valid (ld_valid),
    .ld_value (ld_value),
    .wr_en    (wr_en),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .q        (cfg_q)
  );

  io_window_match #(.AW(IO_AW)) u_io (
    .io_addr   (io_addr),
    .base_byte (cfg_q[15:8]),
    .hit       (io_hit)
  );

  assign span = rom_span_e'(cfg_q[7:6]);

  rom_window_match #(.MAW(MEM_AW), .LSB(ROM_LSB), .NB(ROM_NB)) u_rom (
    .mem_addr (mem_addr),
    .span     (span),
    .base     (cfg_q[5:1]),
    .rd_n     (mem_rd_n),
    .hit      (rom_hit)
  );

  assign io_sel  = isa_mode && io_hit;
  assign rom_sel = isa_mode && rom_hit;
endmodule

// File: rtl/isa_addr_decoder_chk.sv
module isa_addr_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        isa_mode,
  input logic        ld_valid,
  input logic [15:0] ld_value,
  input logic        wr_en,
  input logic [15:0] cfg_q,
  input logic [15:0] io_addr,
  input logic [23:0] mem_addr,
  input logic        mem_rd_n,
  input logic        io_sel,
  input logic        rom_sel
);
  a_r10_mode_gate: assert property (@(posedge clk) disable iff (rst)
    !isa_mode |-> (!io_sel && !rom_sel));

  a_r9_read_only: assert property (@(posedge clk) disable iff (rst)
    mem_rd_n |-> !rom_sel);

  a_r8_a19_high: assert property (@(posedge clk) disable iff (rst)
    rom_sel |-> mem_addr[19]);

  a_r6_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[7:6] == 2'b00) |-> !rom_sel);

  a_r5_zero_lines: assert property (@(posedge clk) disable iff (rst)
    io_sel |-> ((io_addr[12:10] == 3'b000) && !io_addr[4]));

  a_r4_base_lines: assert property (@(posedge clk) disable iff (rst)
    io_sel |-> ((io_addr[15:13] == cfg_q[15:13]) && (io_addr[9:5] == cfg_q[12:8])));

  a_r3_loader_wins: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> (cfg_q == $past(ld_value)));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!ld_valid && !wr_en) |=> $stable(cfg_q));
endmodule

bind isa_addr_decoder isa_addr_decoder_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .isa_mode (isa_mode),
  .ld_valid (ld_valid),
  .ld_value (ld_value),
  .wr_en    (wr_en),
  .cfg_q    (cfg_q),
  .io_addr  (io_addr),
  .mem_addr (mem_addr),
  .mem_rd_n (mem_rd_n),
  .io_sel   (io_sel),
  .rom_sel  (rom_sel)
);

// File: tb/isa_addr_decoder_test.sv
module isa_addr_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        isa_mode = 1'b0;
  logic        ld_valid = 1'b0;
  logic [15:0] ld_value = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cfg_q;
  logic [15:0] io_addr = '0;
  logic [23:0] mem_addr = '0;
  logic        mem_rd_n = 1'b1;
  logic        io_sel, rom_sel;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  isa_addr_decoder uut (
    .clk(clk), .rst(rst), .isa_mode(isa_mode),
    .ld_valid(ld_valid), .ld_value(ld_value),
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .cfg_q(cfg_q), .io_addr(io_addr), .mem_addr(mem_addr),
    .mem_rd_n(mem_rd_n), .io_sel(io_sel), .rom_sel(rom_sel)
  );

  // {cfg, io_addr, mem_addr, rd_n, mode, exp_io, exp_rom}
  localparam int NV = 15;
  localparam logic [59:0] VEC [NV] = '{
    {16'h1867, 16'h0300, 24'h0CC000, 1'b0, 1'b1, 1'b1, 1'b1}, // R4 R7 defaults
    {16'h1867, 16'h030F, 24'h0CFFFF, 1'b0, 1'b1, 1'b1, 1'b1}, // R5 low lines free
    {16'h1867, 16'h0310, 24'h0D0000, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 A4 set
    {16'h1867, 16'h0700, 24'h0CC000, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 A10, R9 no read
    {16'h1867, 16'h2300, 24'h04C000, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 A13, R8 A19 low
    {16'h1867, 16'h0300, 24'hFCC000, 1'b0, 1'b0, 1'b0, 1'b0}, // R10 mode low
    {16'h1867, 16'h0300, 24'hFCC000, 1'b0, 1'b1, 1'b1, 1'b1}, // R8 top lines ignored
    {16'h18A6, 16'h0300, 24'h0C8000, 1'b0, 1'b1, 1'b1, 1'b1}, // R7 32k
    {16'h18A6, 16'h0000, 24'h0CFFFF, 1'b0, 1'b1, 1'b0, 1'b1}, // R7 32k top
    {16'h18A6, 16'h0300, 24'h0C4000, 1'b0, 1'b1, 1'b1, 1'b0}, // R7 32k miss
    {16'h18E6, 16'h0300, 24'h0C0000, 1'b0, 1'b1, 1'b1, 1'b1}, // R7 64k
    {16'h18E6, 16'h1300, 24'h0D0000, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 A12, R7 64k miss
    {16'h1826, 16'h0300, 24'h0CC000, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 disabled
    {16'hA167, 16'hA02F, 24'h0CC000, 1'b0, 1'b1, 1'b1, 1'b1}, // R4 moved base
    {16'hA167, 16'hA820, 24'h0BC000, 1'b0, 1'b1, 1'b0, 1'b0}  // R5 A11, R7 miss
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic load_word(input logic [15:0] w);
    @(negedge clk);
    ld_valid = 1'b1; ld_value = w;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic host_write(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 check("R1 reset word", 32'(cfg_q), 32'h1867);

    // Table walk: R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      load_word(VEC[i][59:44]);
      io_addr  = VEC[i][43:28];
      mem_addr = VEC[i][27:4];
      mem_rd_n = VEC[i][3];
      isa_mode = VEC[i][2];
      #1;
      check($sformatf("R4 R5 row %0d io_sel", i), 32'(io_sel), 32'(VEC[i][1]));
      check($sformatf("R6 R7 R8 R9 R10 row %0d rom_sel", i), 32'(rom_sel), 32'(VEC[i][0]));
    end

    // R2: byte lanes
    load_word(16'h0000);
    host_write(2'b01, 16'hABCD);
    #1 check("R2 low byte only", 32'(cfg_q), 32'h00CD);
    host_write(2'b10, 16'h12EF);
    #1 check("R2 high byte only", 32'(cfg_q), 32'h12CD);
    host_write(2'b00, 16'hFFFF);
    #1 check("R2 no enables", 32'(cfg_q), 32'h12CD);

    // R3: loader beats host in same cycle
    @(negedge clk);
    ld_valid = 1'b1; ld_value = 16'h5555;
    wr_en = 1'b1; wr_be = 2'b11; wr_data = 16'hFFFF;
    @(negedge clk);
    ld_valid = 1'b0; wr_en = 1'b0; wr_be = '0;
    #1 check("R3 loader priority", 32'(cfg_q), 32'h5555);

    // R11: selects follow stored word only after the edge
    load_word(16'h1867);
    isa_mode = 1'b1; io_addr = 16'h0300; mem_addr = 24'h0CC000; mem_rd_n = 1'b0;
    #1 check("R11 baseline io_sel", 32'(io_sel), 32'd1);
    @(negedge clk);
    wr_en = 1'b1; wr_be = 2'b10; wr_data = 16'h2000;
    #1 check("R11 before edge io_sel", 32'(io_sel), 32'd1);
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
    #1 check("R11 after edge io_sel", 32'(io_sel), 32'd0);
    check("R11 rom unchanged", 32'(rom_sel), 32'd1);

    // R1: reset mid-run restores defaults
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1 check("R1 reset again", 32'(cfg_q), 32'h1867);
    check("R1 default io window", 32'(io_sel), 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule